// File: doc/BRIEF.md
# Clock Fanout Gating Controller

This block is the digital control plane of a twelve-pair clock fanout buffer. A fast system clock oversamples a two-wire serial bus on which the block acts as a block-transfer slave. It holds two control bytes: one carries per-pair output enables and two drive-strength bits, and the other carries the remaining enables. From those enables it gates one reference clock onto twelve output pairs and one feedback output. Each output pin is modelled as a value plus an output-enable. While an output-enable is low, the value is held at 0.

A mode input picks between an all-differential arrangement and a mixed arrangement. In the mixed arrangement, four pairs become single-ended in-phase copies and two pairs go to high impedance. An active-low power-down input puts every output in high impedance. An enable change reaches the pins only on a system clock edge where the reference clock is sampled low, so that no output gets a shortened high pulse.

Top module: `clkfan_ctrl`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 followed by the direction bit. It does not acknowledge any other address and then ignores the transfer.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. Each following byte is acknowledged and stored into register bytes 0, 1, 2 and up, in that order.
- R3: A read returns 0x09 first, then register bytes 0, 1, 2 and up. Bytes 0 to 5 and all bytes above 7 read 0x00, and writes to them change nothing.
- R4: Byte 6 is laid out as follows. Bit 7 reads the mode input and ignores writes. Bit 6 is the SDRAM drive boost, output on `boost_sdram`. Bit 5 is the DDR drive boost, output on `boost_ddr`. Bit 4 always reads 0. Bits 3..0 enable pairs 11..8.
- R5: Byte 7 bit k enables pair k, for k from 0 to 7. A 1 enables the pair.
- R6: After reset, every pair enable is 1 and both boost bits are 0.
- R7: While `pwr_n` is 0, every `pair_oe` bit and `fb_oe` are 0, and all output values are 0.
- R8: With `mode_ddr`=1, all twelve pairs are driven. An enabled pair gives `pair_t`=`ref_clk` and `pair_c`=~`ref_clk`. The feedback output `fb_out` follows `ref_clk` whenever power is on.
- R9: With `mode_ddr`=0, pairs 0 and 5 have their output-enable at 0. On enabled pairs 1 to 4, both pins equal `ref_clk`. Pairs 6 to 11 behave as in R8.
- R10: A pair that is driven but disabled holds both of its pins at 0.
- R11: A written enable reaches the pins only at a system clock edge where `ref_clk` is sampled 0. While `ref_clk` stays 1, the pins keep the old enables.
- R12: A STOP or a repeated START ends the current transfer. The next transfer begins again at the command byte for a write, or at the count byte for a read.
- R13: When the master does not acknowledge a read byte, the slave releases SDA and stays off the bus until the next START.
- R14: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line as seen at the pin |
| sda_in | input | 1 | Serial bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| mode_ddr | input | 1 | 1 all-differential, 0 mixed single-ended |
| pwr_n | input | 1 | 0 puts all outputs in high impedance |
| pair_t | output | 12 | True pin value per pair |
| pair_c | output | 12 | Complement pin value per pair |
| pair_oe | output | 12 | Output-enable for both pins of each pair |
| fb_out | output | 1 | Feedback clock value |
| fb_oe | output | 1 | Feedback output-enable |
| boost_sdram | output | 1 | SDRAM drive-boost register bit |
| boost_ddr | output | 1 | DDR drive-boost register bit |

## Verification
A byte pointer that drifts shows up as a misplaced readback byte within the same read transfer. It can also show up as an enable landing on the wrong pair once the reference clock next goes low. A slave state machine in the wrong state shows within one bit time, as a wrong acknowledge bit or as SDA held past a master NACK. A stale or early gating register shows on the pair pins at the first system clock after the reference clock falls. For that reason the bench's model of the pins is compared on every clock.

// File: rtl/clkfan_pkg.sv
// Shared types and constants for the clock fanout controller.
// Assumes a single system clock domain; all bus lines are synchronised first.
package clkfan_pkg;
    localparam int NUM_PAIRS = 12;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_ADDR,
        SL_WR,
        SL_RD
    } slave_st_e;
endpackage

// File: rtl/clkfan_sync.sv
// Multi-bit level synchroniser for slow asynchronous inputs.
// Assumes each bit is independent and held far longer than STAGES clocks.
module clkfan_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // purpose: capture the raw pins, idle-high on reset
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '1;
                    else        stg[0] <= d;
                end
            end else begin : g_rest
                // purpose: further metastability settling stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '1;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkfan_smb_slave.sv
// Block-transfer serial bus slave working on synchronised SCL/SDA.
// Write: command and count bytes are dropped, then data fills bytes 0,1,..
// Read: a fixed count byte leads, then bytes 0,1,.. follow.
// Assumes SCL/SDA are held several system clocks per level.
module clkfan_smb_slave
    import clkfan_pkg::*;
#(
    parameter logic [6:0]        SLAVE_ADDR = 7'h69,
    parameter logic [BYTE_W-1:0] COUNT_BYTE = 8'h09,
    parameter int                PTR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_q,
    input  logic              sda_q,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_idx,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam logic [PTR_W-1:0] PTR_MAX  = '1;
    localparam logic [PTR_W-1:0] HDR_LEN  = PTR_W'(2);
    localparam logic [3:0]       CNT_FULL = 4'd8;
    localparam logic [3:0]       CNT_ACK  = 4'd9;
    localparam logic [3:0]       CNT_NEXT = 4'd10;

    slave_st_e          state;
    logic [3:0]         cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  tx;
    logic [PTR_W-1:0]   ptr;
    logic               rw;
    logic               scl_p, sda_p;
    logic               rise, fall, start, stop;
    logic [BYTE_W-1:0]  next_byte;

    // purpose: remember previous bus levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    // purpose: decode bus events from level history
    always_comb begin
        rise  = scl_q && !scl_p;
        fall  = !scl_q && scl_p;
        start = scl_q && scl_p && sda_p && !sda_q;
        stop  = scl_q && scl_p && !sda_p && sda_q;
    end

    // purpose: select the byte to transmit at the current read pointer
    always_comb begin
        rd_idx    = ptr - PTR_W'(1);
        next_byte = (ptr == '0) ? COUNT_BYTE : rd_data;
    end

    // purpose: bit/byte sequencing of the slave protocol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SL_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start) begin
                state  <= SL_ADDR;
                cnt    <= '0;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else if (stop) begin
                state  <= SL_IDLE;
                cnt    <= '0;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    SL_ADDR, SL_WR: begin
                        if (rise && cnt < CNT_FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_q};
                            cnt   <= cnt + 4'd1;
                        end else if (fall && cnt == CNT_FULL) begin
                            if (state == SL_ADDR) begin
                                if (shreg[BYTE_W-1:1] == SLAVE_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    cnt    <= CNT_ACK;
                                end else begin
                                    state <= SL_IDLE;
                                    cnt   <= '0;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                cnt    <= CNT_ACK;
                                if (ptr >= HDR_LEN) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr - HDR_LEN;
                                    wr_data <= shreg;
                                end
                                if (ptr != PTR_MAX) ptr <= ptr + PTR_W'(1);
                            end
                        end else if (fall && cnt == CNT_ACK) begin
                            if (state == SL_ADDR && rw) begin
                                state  <= SL_RD;
                                tx     <= {next_byte[BYTE_W-2:0], 1'b0};
                                sda_oe <= !next_byte[BYTE_W-1];
                                cnt    <= 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= SL_WR;
                            end
                        end
                    end
                    SL_RD: begin
                        if (fall && cnt < CNT_FULL) begin
                            sda_oe <= !tx[BYTE_W-1];
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end else if (fall && cnt == CNT_FULL) begin
                            sda_oe <= 1'b0;
                            cnt    <= CNT_ACK;
                        end else if (rise && cnt == CNT_ACK) begin
                            if (sda_q) begin
                                state <= SL_IDLE;
                                cnt   <= '0;
                            end else begin
                                if (ptr != PTR_MAX) ptr <= ptr + PTR_W'(1);
                                cnt <= CNT_NEXT;
                            end
                        end else if (fall && cnt == CNT_NEXT) begin
                            tx     <= {next_byte[BYTE_W-2:0], 1'b0};
                            sda_oe <= !next_byte[BYTE_W-1];
                            cnt    <= 4'd1;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/clkfan_regs.sv
// Two control bytes: drive boosts plus upper enables, and lower enables.
// Other byte indices read zero and drop writes. Assumes one write per strobe.
module clkfan_regs
    import clkfan_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     wr_idx,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [PTR_W-1:0]     rd_idx,
    input  logic                 mode_ddr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic                 boost_sdram,
    output logic                 boost_ddr
);
    localparam logic [PTR_W-1:0]  IDX_CTRL  = PTR_W'(6);
    localparam logic [PTR_W-1:0]  IDX_LOW   = PTR_W'(7);
    localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h6F;
    localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h0F;

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] low_q;

    // purpose: store written control bytes, keeping only writable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            low_q  <= '1;
        end else if (wr_en) begin
            if (wr_idx == IDX_CTRL) ctrl_q <= wr_data & CTRL_MASK;
            if (wr_idx == IDX_LOW)  low_q  <= wr_data;
        end
    end

    // purpose: readback mux with the mode pin mirrored into bit 7
    always_comb begin
        if (rd_idx == IDX_CTRL)     rd_data = ctrl_q | {mode_ddr, 7'd0};
        else if (rd_idx == IDX_LOW) rd_data = low_q;
        else                        rd_data = '0;
    end

    assign pair_en     = {ctrl_q[3:0], low_q};
    assign boost_sdram = ctrl_q[6];
    assign boost_ddr   = ctrl_q[5];
endmodule

// File: rtl/clkfan_outmap.sv
// Gates the reference clock onto each pair according to enables and mode.
// Enables are re-timed only when ref_clk is sampled low, so no runt pulse.
// Assumes ref_clk is much slower than clk and stable at each clk edge.
module clkfan_outmap
    import clkfan_pkg::*;
#(
    parameter int SDR_FIRST = 1,
    parameter int SDR_LAST  = 4,
    parameter int OFF_A     = 0,
    parameter int OFF_B     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_clk,
    input  logic                 mode_ddr,
    input  logic                 pwr_n,
    input  logic [NUM_PAIRS-1:0] pair_en,
    output logic [NUM_PAIRS-1:0] en_eff,
    output logic [NUM_PAIRS-1:0] pair_t,
    output logic [NUM_PAIRS-1:0] pair_c,
    output logic [NUM_PAIRS-1:0] pair_oe,
    output logic                 fb_out,
    output logic                 fb_oe
);
    // purpose: accept new enables only while the reference clock is low
    always_ff @(posedge clk) begin
        if (!rst_n)        en_eff <= '1;
        else if (!ref_clk) en_eff <= pair_en;
    end

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam bit IS_SDR = (p >= SDR_FIRST) && (p <= SDR_LAST);
            localparam bit IS_OFF = (p == OFF_A) || (p == OFF_B);
            logic drive, live;
            // purpose: per-pair drive decision and pin values
            always_comb begin
                drive      = pwr_n && !(IS_OFF && !mode_ddr);
                live       = drive && en_eff[p];
                pair_oe[p] = drive;
                pair_t[p]  = live && ref_clk;
                pair_c[p]  = live && ((IS_SDR && !mode_ddr) ? ref_clk : !ref_clk);
            end
        end
    endgenerate

    assign fb_oe  = pwr_n;
    assign fb_out = pwr_n && ref_clk;
endmodule

// File: rtl/clkfan_ctrl.sv
// Top level: bus synchroniser, block-transfer slave, control bytes and
// the output gating map. Assumes clk is far faster than SCL and ref_clk.
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter logic [7:0] COUNT_BYTE  = 8'h09,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic        ref_clk,
    input  logic        mode_ddr,
    input  logic        pwr_n,
    output logic [11:0] pair_t,
    output logic [11:0] pair_c,
    output logic [11:0] pair_oe,
    output logic        fb_out,
    output logic        fb_oe,
    output logic        boost_sdram,
    output logic        boost_ddr
);
    logic [1:0]           bus_q;
    logic                 scl_q, sda_q;
    logic                 wr_en;
    logic [PTR_W-1:0]     wr_idx, rd_idx;
    logic [BYTE_W-1:0]    wr_data, rd_data;
    logic [NUM_PAIRS-1:0] pair_en, en_eff;

    clkfan_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(bus_q)
    );
    assign scl_q = bus_q[1];
    assign sda_q = bus_q[0];

    clkfan_smb_slave #(
        .SLAVE_ADDR(SLAVE_ADDR), .COUNT_BYTE(COUNT_BYTE), .PTR_W(PTR_W)
    ) u_slave (
        .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    clkfan_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .mode_ddr(mode_ddr),
        .rd_data(rd_data), .pair_en(pair_en),
        .boost_sdram(boost_sdram), .boost_ddr(boost_ddr)
    );

    clkfan_outmap u_outmap (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .mode_ddr(mode_ddr),
        .pwr_n(pwr_n), .pair_en(pair_en), .en_eff(en_eff),
        .pair_t(pair_t), .pair_c(pair_c), .pair_oe(pair_oe),
        .fb_out(fb_out), .fb_oe(fb_oe)
    );
endmodule

// File: rtl/clkfan_ctrl_chk.sv
// Property checker for clkfan_ctrl, attached by bind below.
// Assumes the default pair roles (off pairs 0 and 5).
module clkfan_ctrl_chk #(
    parameter int NP    = 12,
    parameter int OFF_A = 0,
    parameter int OFF_B = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_clk,
    input logic          mode_ddr,
    input logic          pwr_n,
    input logic [NP-1:0] pair_t,
    input logic [NP-1:0] pair_c,
    input logic [NP-1:0] pair_oe,
    input logic          fb_oe,
    input logic [NP-1:0] en_eff,
    input logic          scl_q,
    input logic          sda_oe
);
    assert_pd_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |-> (pair_oe == '0) && !fb_oe);

    assert_sdram_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_n && !mode_ddr) |-> !pair_oe[OFF_A] && !pair_oe[OFF_B]);

    assert_gate_when_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff != $past(en_eff)) |-> !$past(ref_clk));

    assert_sda_scl_low_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_q));

    generate
        for (genvar p = 0; p < NP; p++) begin : g_p
            assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (pair_oe[p] && !en_eff[p]) |-> !pair_t[p] && !pair_c[p]);
            assert_ddr_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_ddr && pair_oe[p] && en_eff[p]) |-> (pair_c[p] == !pair_t[p]));
        end
    endgenerate
endmodule

bind clkfan_ctrl clkfan_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .mode_ddr(mode_ddr),
    .pwr_n(pwr_n), .pair_t(pair_t), .pair_c(pair_c), .pair_oe(pair_oe),
    .fb_oe(fb_oe), .en_eff(en_eff), .scl_q(scl_q), .sda_oe(sda_oe)
);

// File: tb/test_clkfan_ctrl.sv
module test_clkfan_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic ref_clk = 1'b1, mode_ddr = 1'b1, pwr_n = 1'b1;
    logic sda_oe, fb_out, fb_oe, boost_sdram, boost_ddr;
    logic [11:0] pair_t, pair_c, pair_oe;
    wire sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    clkfan_ctrl i_clkfan_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .ref_clk(ref_clk), .mode_ddr(mode_ddr), .pwr_n(pwr_n),
        .pair_t(pair_t), .pair_c(pair_c), .pair_oe(pair_oe),
        .fb_out(fb_out), .fb_oe(fb_oe),
        .boost_sdram(boost_sdram), .boost_ddr(boost_ddr)
    );

    int n_run = 0, n_fail = 0;
    bit busy = 1'b0;
    logic [11:0] mdl_en = '1, mdl_eff = '1;
    logic mdl_bs = 1'b0, mdl_bd = 1'b0;
    logic [11:0] e_t, e_c, e_oe;
    localparam int H = 8;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference: enables move to the pins only when ref_clk sampled low (R11)
    always @(posedge clk) begin
        if (!rst_n)        mdl_eff <= '1;
        else if (!ref_clk) mdl_eff <= mdl_en;
    end

    // cycle-by-cycle comparison of every output pin against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int p = 0; p < 12; p++) begin
                e_oe[p] = pwr_n && !(!mode_ddr && (p == 0 || p == 5));
                e_t[p]  = e_oe[p] && mdl_eff[p] && ref_clk;
                e_c[p]  = e_oe[p] && mdl_eff[p] &&
                          ((!mode_ddr && p >= 1 && p <= 4) ? ref_clk : !ref_clk);
            end
            chk("R8 R9 R10 R11 pair pins", {pair_oe, pair_t, pair_c}, {e_oe, e_t, e_c});
            chk("R7 R8 feedback", {fb_oe, fb_out}, {pwr_n, pwr_n & ref_clk});
            if (!busy) chk("R4 boost pins", {boost_sdram, boost_ddr}, {mdl_bs, mdl_bd});
        end
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask
    task automatic bus_start();
        sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
    endtask
    task automatic bus_bit(input logic b, output logic r);
        sda_m = b; hw(); scl_m = 1'b1; hw(); r = sda_bus; hw(); scl_m = 1'b0; hw();
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
        bus_bit(1'b1, ack);
    endtask
    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        bus_bit(mack, r);
    endtask

    // full write: command, count, bytes 0..7 and one byte past the map
    task automatic wr_regs(input logic [7:0] b6, input logic [7:0] b7);
        logic ack;
        busy = 1'b1;
        bus_start();
        put_byte(8'hD2, ack); chk("R1 write address ack", ack, 1'b0);
        put_byte(8'h3C, ack); chk("R2 command byte ack", ack, 1'b0);
        put_byte(8'h77, ack); chk("R2 count byte ack", ack, 1'b0);
        for (int i = 0; i < 9; i++) begin
            put_byte((i == 6) ? b6 : (i == 7) ? b7 : 8'hFF, ack);
            chk("R2 data byte ack", ack, 1'b0);
        end
        bus_stop();
        mdl_en = {b6[3:0], b7};
        mdl_bs = b6[6];
        mdl_bd = b6[5];
        busy = 1'b0;
    endtask

    // full read of count byte plus bytes 0..7, compared with the model
    task automatic rd_check(input string ctx);
        logic ack;
        logic [7:0] d;
        bus_start();
        put_byte(8'hD3, ack); chk({"R1 read address ack ", ctx}, ack, 1'b0);
        get_byte(1'b0, d); chk({"R3 R12 R14 count byte ", ctx}, d, 8'h09);
        for (int i = 0; i < 8; i++) begin
            get_byte(i == 7, d);
            if (i < 6)       chk({"R3 unused byte ", ctx}, d, 8'h00);
            else if (i == 6) chk({"R4 control byte ", ctx}, d,
                                 {mode_ddr, mdl_bs, mdl_bd, 1'b0, mdl_en[11:8]});
            else             chk({"R5 low enable byte ", ctx}, d, mdl_en[7:0]);
        end
        bus_stop();
    endtask

    task automatic run_ref(input int halves);
        for (int i = 0; i < halves; i++) begin
            repeat (3) @(negedge clk);
            ref_clk = ~ref_clk;
        end
        if (!ref_clk) begin
            repeat (3) @(negedge clk);
            ref_clk = 1'b1;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 reset state at the pins and through readback
        chk("R6 reset boosts", {boost_sdram, boost_ddr}, 2'b00);
        chk("R6 reset pair oe", pair_oe, 12'hFFF);
        rd_check("after reset R6");

        // R8 all-differential pairs
        run_ref(20);
        ref_clk = 1'b0; repeat (2) @(negedge clk);
        chk("R8 true low phase", pair_t, 12'h000);
        chk("R8 complement low phase", pair_c, 12'hFFF);
        chk("R8 feedback low phase", fb_out, 1'b0);
        ref_clk = 1'b1; repeat (2) @(negedge clk);
        chk("R8 true high phase", pair_t, 12'hFFF);

        // R2 R4 R5 write, R11 held while ref_clk stays high
        wr_regs(8'hF6, 8'hA5);
        chk("R11 old enables held", pair_t, 12'hFFF);
        chk("R4 boosts written", {boost_sdram, boost_ddr}, 2'b11);
        ref_clk = 1'b0; repeat (2) @(negedge clk);
        chk("R10 R11 complement after gate", pair_c, 12'h6A5);
        chk("R10 true low", pair_t, 12'h000);
        ref_clk = 1'b1; repeat (2) @(negedge clk);
        chk("R10 true high", pair_t, 12'h6A5);
        rd_check("after write R2");

        // R9 mixed mode, bit 7 read-only
        mode_ddr = 1'b0;
        wr_regs(8'h8F, 8'hFF);
        run_ref(16);
        chk("R9 pair oe", pair_oe, 12'hFDE);
        chk("R9 true high", pair_t, 12'hFDE);
        chk("R9 complement high", pair_c, 12'h01E);
        ref_clk = 1'b0; repeat (2) @(negedge clk);
        chk("R9 complement low", pair_c, 12'hFC0);
        ref_clk = 1'b1; repeat (2) @(negedge clk);
        rd_check("mixed mode R9");

        // R7 power-down
        pwr_n = 1'b0; repeat (2) @(negedge clk);
        chk("R7 pair oe", pair_oe, 12'h000);
        chk("R7 pair values", {pair_t, pair_c}, 24'h0);
        chk("R7 feedback oe", fb_oe, 1'b0);
        pwr_n = 1'b1;
        mode_ddr = 1'b1;
        repeat (2) @(negedge clk);

        // R1 foreign addresses are not acknowledged and change nothing
        busy = 1'b1;
        bus_start();
        put_byte(8'hA4, ack); chk("R1 foreign address nack", ack, 1'b1);
        put_byte(8'h00, ack);
        bus_stop();
        bus_start();
        put_byte(8'hD0, ack); chk("R1 near address nack", ack, 1'b1);
        bus_stop();
        busy = 1'b0;
        rd_check("after foreign R1");

        // R12 repeated START restarts at the command byte
        busy = 1'b1;
        bus_start();
        put_byte(8'hD2, ack);
        put_byte(8'h01, ack);
        put_byte(8'h08, ack);
        for (int i = 0; i < 6; i++) put_byte(8'h11, ack);
        bus_start();
        put_byte(8'hD2, ack); chk("R12 restart address ack", ack, 1'b0);
        put_byte(8'h40, ack);
        put_byte(8'h40, ack);
        put_byte(8'h40, ack);
        for (int i = 0; i < 5; i++) put_byte(8'h00, ack);
        put_byte(8'h2F, ack);
        put_byte(8'h3C, ack);
        bus_stop();
        mdl_en = 12'hF3C; mdl_bs = 1'b0; mdl_bd = 1'b1;
        busy = 1'b0;
        chk("R12 boosts after restart", {boost_sdram, boost_ddr}, 2'b01);
        rd_check("after restart R12");

        // R13 master NACK releases the bus
        bus_start();
        put_byte(8'hD3, ack);
        get_byte(1'b1, d); chk("R13 count before nack", d, 8'h09);
        get_byte(1'b1, d); chk("R13 bus released", d, 8'hFF);
        bus_stop();
        rd_check("after nack R13");

        run_ref(12);
        report();
    end
endmodule